// File: doc/BRIEF.md
# Serial LCD Register Access Engine

This block is a bit-timed serial master that lets a host read and write 16-bit registers inside an LCD panel controller over a four-wire link: an active-low select, a serial clock, a host-to-panel data line and a panel-to-host data line. The host raises a one-cycle request carrying a read/write flag, an 8-bit register index and, for writes, a 16-bit value. The block turns that request into two 24-bit frames and reports the end of the second frame with a one-cycle done pulse. For reads it also presents the 16-bit result.

Every frame starts with a header byte. The header holds a fixed 6-bit device tag (binary 011101) in its upper six bits and a 2-bit select code in its lower two bits. The 16-bit payload follows. The first frame of every access sets the register index. The second frame either writes the value or clocks the result back from the panel. Bit timing comes from a half-period counter set by a parameter. Select is released, and the link rests, for one half period between the two frames and again after the second frame.

Top module: `lcd_reg_engine`

## Requirements
- R1: During reset and while idle, select, serial clock and the output data line are all high, busy is low and done is low.
- R2: Each frame holds select low for its whole length and gives exactly 24 rising clock edges, most significant bit first. The serial clock is never low while select is high.
- R3: The first frame of every access is 0x74 in bits 23:16, 0x00 in bits 15:8 and the register index in bits 7:0. The header 0x74 is the device tag with select code 0 (index write).
- R4: For a write, the second frame is 0x76 (select code 2, data write) in bits 23:16 and the 16-bit value in bits 15:0.
- R5: For a read, the second frame is 0x77 (select code 3, data read) followed by sixteen zero bits. The result is the last 16 bits sampled from the input data line during that frame, taken most significant first. Each bit is sampled at the end of the clock-low phase.
- R6: Every clock-low phase and every clock-high phase lasts exactly HALF_CYCLES clock cycles. The output data line does not change within a bit.
- R7: After select falls, the clock stays high for HALF_CYCLES cycles before the first falling edge. After the last rising edge, select rises HALF_CYCLES cycles later.
- R8: Select stays high for exactly HALF_CYCLES cycles between the two frames of an access. Busy is high from the cycle after a request is accepted until the access ends. A request raised while busy is ignored.
- R9: Done pulses high for exactly one cycle, with busy low, when the second frame's trailing wait ends. The read result changes only on the done of a read; a write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken only while busy is low |
| rd_i | input | 1 | 1 = register read, 0 = register write |
| idx_i | input | 8 | Register index |
| wdata_i | input | 16 | Write value |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle end-of-access pulse |
| rdata_o | output | 16 | Result of the most recent read |
| spi_csn_o | output | 1 | Panel select, active low |
| spi_sclk_o | output | 1 | Serial clock, idles high |
| spi_mosi_o | output | 1 | Serial data to the panel |
| spi_miso_i | input | 1 | Serial data from the panel |

## Verification
The bench has the panel answer the index frame with a junk word and the data frame with a known word. A design that latched the result from the wrong frame, or kept the upper byte instead of the last sixteen bits, would return the wrong value. It measures every clock phase, the lead time, the gap between frames and the bit count. A half-period counter that is off by one, or a frame one bit short, would show up as a wrong length. It raises a second request in the middle of an access and issues requests back to back on the done cycle, so a design that accepted work while busy or dropped a request at the edge would produce extra or missing frames. Writes are checked to leave the last read result in place.

// File: rtl/lcd_reg_pkg.sv
package lcd_reg_pkg;
  localparam int FRAME_BITS   = 24;
  localparam int PAYLOAD_BITS = 16;
  localparam int IDX_BITS     = 8;
  localparam int HDR_BITS     = FRAME_BITS - PAYLOAD_BITS;
  localparam logic [HDR_BITS-3:0] DEV_TAG = 6'h1D;

  typedef enum logic [1:0] {
    CODE_IDX_WR  = 2'd0,
    CODE_STAT_RD = 2'd1,
    CODE_DAT_WR  = 2'd2,
    CODE_DAT_RD  = 2'd3
  } sel_code_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_LOW,
    ST_HIGH,
    ST_TRAIL
  } phase_e;

  function automatic logic [FRAME_BITS-1:0] make_frame(sel_code_e code,
                                                        logic [PAYLOAD_BITS-1:0] payload);
    return {DEV_TAG, code, payload};
  endfunction
endpackage

// File: rtl/lcd_half_timer.sv
module lcd_half_timer #(
  parameter int HALF_CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic tick_o
);
  localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(HALF_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (start_i)        cnt_q <= RELOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign tick_o = (cnt_q == '0);

  AST_TICK_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (tick_o == (HALF_CYCLES == 1))); // R6
endmodule

// File: rtl/lcd_frame_shift.sv
module lcd_frame_shift #(
  parameter int BITS = 24,
  parameter int KEEP = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [BITS-1:0] load_word_i,
  input  logic            shift_i,
  input  logic            sample_i,
  input  logic            miso_i,
  output logic            mosi_bit_o,
  output logic            last_o,
  output logic [KEEP-1:0] rx_o
);
  localparam int CW = $clog2(BITS);
  localparam logic [CW-1:0] LAST_IDX = CW'(BITS - 1);

  logic [BITS-1:0] tx_q;
  logic [KEEP-1:0] rx_q;
  logic [CW-1:0]   left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= '1;
      rx_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      tx_q   <= load_word_i;
      rx_q   <= '0;
      left_q <= LAST_IDX;
    end else begin
      if (shift_i) begin
        tx_q   <= {tx_q[BITS-2:0], 1'b1};
        left_q <= left_q - 1'b1;
      end
      if (sample_i) rx_q <= {rx_q[KEEP-2:0], miso_i};
    end
  end

  assign mosi_bit_o = tx_q[BITS-1];
  assign last_o     = (left_q == '0);
  assign rx_o       = rx_q;

  AST_NO_OVERSHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> !last_o); // R2
endmodule

// File: rtl/lcd_reg_engine.sv
module lcd_reg_engine
  import lcd_reg_pkg::*;
#(
  parameter int HALF_CYCLES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    rd_i,
  input  logic [IDX_BITS-1:0]     idx_i,
  input  logic [PAYLOAD_BITS-1:0] wdata_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic [PAYLOAD_BITS-1:0] rdata_o,
  output logic                    spi_csn_o,
  output logic                    spi_sclk_o,
  output logic                    spi_mosi_o,
  input  logic                    spi_miso_i
);
  localparam int PAD_BITS = PAYLOAD_BITS - IDX_BITS;

  phase_e                  state_q, state_d;
  logic                    second_q, rd_q, done_q;
  logic [PAYLOAD_BITS-1:0] wdata_q, rdata_q;
  logic                    tick, start, load, shift, sample, fin, last_bit, mosi_bit;
  logic [FRAME_BITS-1:0]   load_word;
  logic [PAYLOAD_BITS-1:0] rx_word;

  lcd_half_timer #(.HALF_CYCLES(HALF_CYCLES)) u_timer (
    .clk_i, .rst_ni, .start_i(start), .tick_o(tick)
  );

  lcd_frame_shift #(.BITS(FRAME_BITS), .KEEP(PAYLOAD_BITS)) u_shift (
    .clk_i, .rst_ni,
    .load_i(load), .load_word_i(load_word),
    .shift_i(shift), .sample_i(sample), .miso_i(spi_miso_i),
    .mosi_bit_o(mosi_bit), .last_o(last_bit), .rx_o(rx_word)
  );

  always_comb begin
    state_d   = state_q;
    start     = 1'b0;
    load      = 1'b0;
    shift     = 1'b0;
    sample    = 1'b0;
    fin       = 1'b0;
    load_word = '1;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d   = ST_LEAD;
        start     = 1'b1;
        load      = 1'b1;
        load_word = make_frame(CODE_IDX_WR, {{PAD_BITS{1'b0}}, idx_i});
      end
      ST_LEAD: if (tick) begin
        state_d = ST_LOW;
        start   = 1'b1;
      end
      ST_LOW: if (tick) begin
        state_d = ST_HIGH;
        start   = 1'b1;
        sample  = 1'b1;
      end
      ST_HIGH: if (tick) begin
        start = 1'b1;
        if (last_bit) state_d = ST_TRAIL;
        else begin
          shift   = 1'b1;
          state_d = ST_LOW;
        end
      end
      ST_TRAIL: if (tick) begin
        if (!second_q) begin
          state_d   = ST_LEAD;
          start     = 1'b1;
          load      = 1'b1;
          load_word = rd_q ? make_frame(CODE_DAT_RD, '0)
                           : make_frame(CODE_DAT_WR, wdata_q);
        end else begin
          state_d = ST_IDLE;
          fin     = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      second_q <= 1'b0;
      rd_q     <= 1'b0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin;
      if (state_q == ST_IDLE && req_i) begin
        rd_q     <= rd_i;
        wdata_q  <= wdata_i;
        second_q <= 1'b0;
      end
      if (state_q == ST_TRAIL && tick) second_q <= 1'b1;
      if (fin && rd_q) rdata_q <= rx_word;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign rdata_o    = rdata_q;
  assign spi_csn_o  = !(state_q inside {ST_LEAD, ST_LOW, ST_HIGH});
  assign spi_sclk_o = (state_q != ST_LOW);
  assign spi_mosi_o = (state_q inside {ST_LOW, ST_HIGH}) ? mosi_bit : 1'b1;

  AST_IDLE_PINS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (spi_csn_o && spi_sclk_o && spi_mosi_o)); // R1
  AST_SCLK_ONLY_SELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spi_sclk_o |-> !spi_csn_o); // R2
  AST_MOSI_HELD_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(spi_sclk_o) && !spi_csn_o) |-> $stable(spi_mosi_o)); // R6
  AST_REQ_IGNORED_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(rd_q) && $stable(wdata_q))); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R9
endmodule

// File: tb/lcd_reg_engine_bench.sv
module lcd_reg_engine_bench;
  localparam int HALF  = 3;
  localparam int LIMIT = 100000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, rd_i = 1'b0;
  logic [7:0]  idx_i = '0;
  logic [15:0] wdata_i = '0;
  logic        busy_o, done_o, spi_csn_o, spi_sclk_o, spi_mosi_o;
  logic        spi_miso_i = 1'b1;
  logic [15:0] rdata_o;

  always #2 clk_i = ~clk_i;

  lcd_reg_engine #(.HALF_CYCLES(HALF)) u_lcd_reg_engine (.*);

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  logic [23:0] exp_frames[$];
  logic [15:0] exp_rd[$];
  logic [23:0] resp_word = '0;
  logic [15:0] model_rd = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  // monitor and panel model, sampled away from the active edge
  logic        p_csn = 1, p_sclk = 1, p_done = 0, low_mosi = 1;
  int          bits = 0, lead_cnt = 0, low_cnt = 0, high_cnt = 0, gap_cnt = 0, frame_no = 0, cyc = 0;
  logic [23:0] cap = '0;

  always @(negedge clk_i) begin
    cyc++;
    if (cyc > LIMIT) begin
      chk(0, "watchdog", cyc, LIMIT);
      finish_run();
    end
    if (rst_ni) begin
      if (p_csn && !spi_csn_o) begin
        if (frame_no % 2 == 1) chk(gap_cnt == HALF, "R8 gap", gap_cnt, HALF);
        bits = 0; cap = '0; lead_cnt = 1;
      end else if (!p_csn && spi_csn_o) begin
        chk(high_cnt == HALF, "R7 trail", high_cnt, HALF);
        chk(bits == 24, "R2 bit count", bits, 24);
        if (exp_frames.size() == 0) chk(0, "R2 unexpected frame", cap, 0);
        else begin
          logic [23:0] e;
          e = exp_frames.pop_front();
          chk(cap == e, frame_no % 2 ? "R4/R5 data frame" : "R3 index frame", cap, e);
        end
        frame_no++; gap_cnt = 1;
      end else if (spi_csn_o) begin
        gap_cnt++;
        chk(spi_sclk_o && spi_mosi_o, "R1 idle pins", {spi_sclk_o, spi_mosi_o}, 2'b11);
      end else if (p_sclk && !spi_sclk_o) begin
        if (bits == 0) chk(lead_cnt == HALF, "R7 lead", lead_cnt, HALF);
        else chk(high_cnt == HALF, "R6 high phase", high_cnt, HALF);
        low_cnt = 1; low_mosi = spi_mosi_o;
        spi_miso_i = (frame_no % 2 == 1) ? resp_word[23-bits] : 24'hC3A55A >> (23-bits);
      end else if (!p_sclk && spi_sclk_o) begin
        chk(low_cnt == HALF, "R6 low phase", low_cnt, HALF);
        chk(spi_mosi_o == low_mosi, "R6 mosi stable", spi_mosi_o, low_mosi);
        cap = {cap[22:0], spi_mosi_o}; bits++; high_cnt = 1;
      end else if (!spi_sclk_o) low_cnt++;
      else if (bits == 0) lead_cnt++;
      else high_cnt++;

      if (done_o) begin
        chk(!p_done, "R9 done one cycle", p_done, 0);
        chk(!busy_o, "R9 done with busy low", busy_o, 0);
        if (exp_rd.size() == 0) chk(0, "R9 unexpected done", 1, 0);
        else begin
          logic [15:0] r;
          r = exp_rd.pop_front();
          chk(rdata_o == r, "R5/R9 read result", rdata_o, r);
        end
      end
    end
    p_csn = spi_csn_o; p_sclk = spi_sclk_o; p_done = done_o;
  end

  task automatic do_access(input bit rd, input logic [7:0] idx, input logic [15:0] wd, input logic [15:0] resp);
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    resp_word = {8'h5A, resp};
    exp_frames.push_back({8'h74, 8'h00, idx});
    exp_frames.push_back(rd ? {8'h77, 16'h0000} : {8'h76, wd});
    if (rd) model_rd = resp;
    exp_rd.push_back(model_rd);
    req_i = 1; rd_i = rd; idx_i = idx; wdata_i = wd;
    @(negedge clk_i);
    req_i = 0;
    chk(busy_o, "R8 busy after accept", busy_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk({spi_csn_o, spi_sclk_o, spi_mosi_o} == 3'b111, "R1 reset pins", {spi_csn_o, spi_sclk_o, spi_mosi_o}, 3'b111);
    chk(!busy_o && !done_o, "R1 reset busy/done", {busy_o, done_o}, 0);
    rst_ni = 1;
    repeat (3) @(negedge clk_i);
    chk({spi_csn_o, spi_sclk_o, spi_mosi_o, busy_o} == 4'b1110, "R1 idle after reset",
        {spi_csn_o, spi_sclk_o, spi_mosi_o, busy_o}, 4'b1110);

    do_access(0, 8'h07, 16'h0015, 16'hDEAD);   // R3 R4
    do_access(1, 8'h00, 16'h0000, 16'h0139);   // R5
    do_access(0, 8'hFF, 16'hFFFF, 16'h1111);   // R9 write keeps result
    do_access(1, 8'hA5, 16'h0000, 16'hFFFF);
    do_access(1, 8'h5A, 16'h0000, 16'h0000);
    do_access(0, 8'h00, 16'h0000, 16'h2222);
    do_access(1, 8'h13, 16'h0000, 16'h8001);

    // R8: a request while busy must not start anything
    do_access(0, 8'h42, 16'h5A5A, 16'h3333);
    repeat (10) @(negedge clk_i);
    req_i = 1; rd_i = 1; idx_i = 8'hEE; wdata_i = 16'h1234;
    @(negedge clk_i);
    req_i = 0;
    do_access(1, 8'h20, 16'h0000, 16'h6C3A);

    @(negedge clk_i);
    while (busy_o || done_o) @(negedge clk_i);
    repeat (4 * HALF) @(negedge clk_i);
    chk(exp_frames.size() == 0, "R2 all frames seen", exp_frames.size(), 0);
    chk(exp_rd.size() == 0, "R9 all accesses done", exp_rd.size(), 0);
    chk(!busy_o && spi_csn_o, "R8 idle at end", {busy_o, spi_csn_o}, 2'b01);
    finish_run();
  end
endmodule